// File: doc/BRIEF.md
# Virtual Channel Send Gate with Credit or Stop-Signal Flow Control

This block sits on the upstream side of one router output port that carries several virtual channels (VCs). It tracks the resources a flit needs before it may leave on the link. The downstream VC must be owned by the flit's packet, or be free if the flit is a head flit. There must be room in the downstream buffer of that VC. The flit must also win the single physical-channel slot of the cycle. Each cycle the block takes one send request per VC, each tagged with head and tail flags, and grants at most one of them. A grant is the cycle's send.

Downstream buffer space is tracked in one of two ways, chosen by a parameter. In credit mode each VC holds a counter of free downstream slots. A grant lowers the counter, and a credit pulse, tagged with a VC number, raises it. In stop-signal mode no counters are kept. Downstream drives one stop line per VC, and a VC may send only while its stop line was low in the previous cycle. The downstream side must assert stop with at least the link round-trip of free slots still left. The buffer depth and the round-trip delay are parameters, and the depth is required to exceed the round trip.

The switch allocator uses the registered eligibility flags to decide which requests to present. It then treats the block's grant vector as the record of which flit went out.

Top module: `vc_send_gate`

## Requirements
- R1: After reset every credit counter equals BUF_DEPTH, every VC reads not busy, and every eligibility flag is 1.
- R2: In credit mode, a grant on VC v lowers that VC's counter by one at the next clock edge. Counters are packed in `credit_cnt`, and VC v occupies bits [v*CNT_W +: CNT_W].
- R3: In credit mode, a credit pulse (`crd_vld` high, `crd_vc` = v) raises VC v's counter by one. A counter never exceeds BUF_DEPTH.
- R4: A credit pulse and a grant on the same VC in the same cycle leave that counter unchanged.
- R5: A VC whose counter is zero shows eligibility 0 and receives no grant, so a counter never underflows.
- R6: A head flit (`req_head` = 1) is granted only if its VC is not busy. Its grant marks the VC busy from the next cycle.
- R7: A flit with `req_head` = 0 is granted only if its VC is busy.
- R8: A granted flit with `req_tail` = 1 leaves its VC not busy from the next cycle. A flit with both head and tail set therefore leaves the VC free.
- R9: At most one grant is raised per cycle. Among the requests that meet all resource checks, the lowest VC index wins.
- R10: In stop-signal mode a VC is eligible exactly when its `stop_in` bit was low at the previous clock edge. Credit pulses have no effect, and `credit_cnt` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | NUM_VC | Per-VC send request |
| req_head | input | NUM_VC | Requesting flit is a head flit |
| req_tail | input | NUM_VC | Requesting flit is a tail flit |
| crd_vld | input | 1 | Credit return pulse from downstream |
| crd_vc | input | VC_W | VC that the credit belongs to |
| stop_in | input | NUM_VC | Per-VC stop line from downstream (stop-signal mode) |
| send_gnt | output | NUM_VC | One-hot grant: the flit sent this cycle |
| vc_elig | output | NUM_VC | Registered buffer-space flag per VC |
| vc_busy | output | NUM_VC | Downstream VC owned by a packet in flight |
| credit_cnt | output | NUM_VC*CNT_W | Packed per-VC free-slot counters |

## Verification
Two events can land on the same counter in one cycle: a send on a VC and a credit return for that same VC. Both touch the same register. The bench provokes this by sending a tail flit on a VC while a credit for that VC is returned. It then expects the counter to hold its value while ownership drops in the next cycle. A second case has a grant and a head-plus-tail release land on one ownership bit together. A pseudo-random phase that keeps credit returns legal then mixes these collisions with contention among VCs. A bench-side model judges every cycle's grant vector and the following counters.

// File: rtl/vc_send_gate_pkg.sv
package vc_send_gate_pkg;
  function automatic int cnt_width(input int depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vcsg_credit.sv
module vcsg_credit #(
  parameter int BUF_DEPTH = 4,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             give,
  output logic [CNT_W-1:0] cnt,
  output logic             has_room
);
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    case ({give, take})
      2'b10:   cnt_n = cnt + CNT_W'(1);
      2'b01:   cnt_n = cnt - CNT_W'(1);
      default: cnt_n = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= CNT_W'(BUF_DEPTH);
      has_room <= 1'b1;
    end else begin
      cnt      <= cnt_n;
      has_room <= (cnt_n != '0);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(BUF_DEPTH));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    take |-> cnt != '0);
  assert_collide_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (take && give) |=> $stable(cnt));
  assert_take_lowers_R2: assert property (@(posedge clk) disable iff (rst)
    (take && !give) |=> cnt == $past(cnt) - CNT_W'(1));
endmodule

// File: rtl/vcsg_owner.sv
module vcsg_owner (
  input  logic clk,
  input  logic rst,
  input  logic claim,
  input  logic drop,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else     busy <= (busy | claim) & ~drop;
  end

  assert_claim_free_R6: assert property (@(posedge clk) disable iff (rst)
    claim |-> !busy);
  assert_drop_frees_R8: assert property (@(posedge clk) disable iff (rst)
    drop |=> !busy);
  assert_claim_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (claim && !drop) |=> busy);
endmodule

// File: rtl/vcsg_pick.sv
module vcsg_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] win
);
  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) win = N'(1) << i;
    end
  end

  always_comb begin
    assert_one_send_R9: assert ($onehot0(win));
  end
endmodule

// File: rtl/vc_send_gate.sv
module vc_send_gate
  import vc_send_gate_pkg::*;
#(
  parameter int NUM_VC     = 4,
  parameter int BUF_DEPTH  = 4,
  parameter int RTT_CYCLES = 2,
  parameter bit STOP_MODE  = 1'b0,
  localparam int VC_W      = idx_width(NUM_VC),
  localparam int CNT_W     = cnt_width(BUF_DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_VC-1:0]       req_vld,
  input  logic [NUM_VC-1:0]       req_head,
  input  logic [NUM_VC-1:0]       req_tail,
  input  logic                    crd_vld,
  input  logic [VC_W-1:0]         crd_vc,
  input  logic [NUM_VC-1:0]       stop_in,
  output logic [NUM_VC-1:0]       send_gnt,
  output logic [NUM_VC-1:0]       vc_elig,
  output logic [NUM_VC-1:0]       vc_busy,
  output logic [NUM_VC*CNT_W-1:0] credit_cnt
);
  localparam int STOP_HEADROOM = BUF_DEPTH - RTT_CYCLES;

  initial begin
    assert_depth_covers_rtt: assert (STOP_HEADROOM >= 1)
      else $error("BUF_DEPTH must exceed RTT_CYCLES");
  end

  logic [NUM_VC-1:0] cand;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    assign cand[v] = req_vld[v] && vc_elig[v] &&
                     (req_head[v] ? !vc_busy[v] : vc_busy[v]);

    vcsg_owner u_own (
      .clk   (clk),
      .rst   (rst),
      .claim (send_gnt[v] & req_head[v]),
      .drop  (send_gnt[v] & req_tail[v]),
      .busy  (vc_busy[v])
    );

    if (STOP_MODE) begin : g_stop
      logic unused_crd;
      assign unused_crd = crd_vld ^ (^crd_vc);
      always_ff @(posedge clk) begin
        if (rst) vc_elig[v] <= 1'b1;
        else     vc_elig[v] <= ~stop_in[v];
      end
      assign credit_cnt[v*CNT_W +: CNT_W] = '0;
    end else begin : g_credit
      logic unused_stop;
      assign unused_stop = stop_in[v];
      vcsg_credit #(.BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_crd (
        .clk      (clk),
        .rst      (rst),
        .take     (send_gnt[v]),
        .give     (crd_vld && (crd_vc == VC_W'(v))),
        .cnt      (credit_cnt[v*CNT_W +: CNT_W]),
        .has_room (vc_elig[v])
      );
    end

    assert_body_owned_R7: assert property (@(posedge clk) disable iff (rst)
      (send_gnt[v] && !req_head[v]) |-> vc_busy[v]);
  end

  vcsg_pick #(.N(NUM_VC)) u_pick (
    .cand (cand),
    .win  (send_gnt)
  );
endmodule

// File: tb/vc_send_gate_tb.sv
module vc_send_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam int DEPTH = 4;
  localparam int RTT = 2;
  localparam int CW = 3;
  localparam int VW = 2;

  logic clk = 0;
  logic rst = 1;
  logic [NV-1:0] req_vld = '0, req_head = '0, req_tail = '0, stop_in = '0;
  logic crd_vld = 0;
  logic [VW-1:0] crd_vc = '0;
  logic [NV-1:0] gnt_c, elig_c, busy_c, gnt_o, elig_o, busy_o;
  logic [NV*CW-1:0] cnt_c, cnt_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  vc_send_gate #(.NUM_VC(NV), .BUF_DEPTH(DEPTH), .RTT_CYCLES(RTT), .STOP_MODE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_head(req_head), .req_tail(req_tail),
    .crd_vld(crd_vld), .crd_vc(crd_vc), .stop_in(stop_in),
    .send_gnt(gnt_c), .vc_elig(elig_c), .vc_busy(busy_c), .credit_cnt(cnt_c));

  vc_send_gate #(.NUM_VC(NV), .BUF_DEPTH(DEPTH), .RTT_CYCLES(RTT), .STOP_MODE(1'b1)) u_dut_stop (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_head(req_head), .req_tail(req_tail),
    .crd_vld(crd_vld), .crd_vc(crd_vc), .stop_in(stop_in),
    .send_gnt(gnt_o), .vc_elig(elig_o), .vc_busy(busy_o), .credit_cnt(cnt_o));

  int checks = 0, fails = 0;
  bit done = 0;

  int m_cnt[NV];
  bit m_busy[NV], m_obusy[NV], m_stopq[NV];

  typedef struct { logic [NV-1:0] gc; logic [NV-1:0] go; string tag; } exp_t;
  exp_t sb[$];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [NV-1:0] lowest(input logic [NV-1:0] c);
    for (int i = 0; i < NV; i++) if (c[i]) return NV'(1) << i;
    return '0;
  endfunction

  task automatic state_check(input string tag);
    for (int v = 0; v < NV; v++) begin
      chk(tag, $sformatf("credit cnt vc%0d", v), int'(cnt_c[v*CW +: CW]), m_cnt[v]);
      chk(tag, $sformatf("credit elig vc%0d", v), int'(elig_c[v]), int'(m_cnt[v] != 0));
      chk(tag, $sformatf("credit busy vc%0d", v), int'(busy_c[v]), int'(m_busy[v]));
      chk(tag, $sformatf("stop elig vc%0d", v), int'(elig_o[v]), int'(!m_stopq[v]));
      chk(tag, $sformatf("stop busy vc%0d", v), int'(busy_o[v]), int'(m_obusy[v]));
      chk(tag, $sformatf("stop cnt vc%0d", v), int'(cnt_o[v*CW +: CW]), 0);
    end
  endtask

  // driver: checks state left by the last edge, drives one cycle, queues expected grants
  task automatic step(input string tag, input logic [NV-1:0] rq, input logic [NV-1:0] hd,
                      input logic [NV-1:0] tl, input bit cv, input int cvc,
                      input logic [NV-1:0] st);
    logic [NV-1:0] cc, co, gc, go;
    exp_t e;
    @(negedge clk);
    state_check(tag);
    req_vld = rq; req_head = hd; req_tail = tl;
    crd_vld = cv; crd_vc = VW'(cvc); stop_in = st;
    for (int v = 0; v < NV; v++) begin
      cc[v] = rq[v] && (m_cnt[v] != 0) && (hd[v] ? !m_busy[v] : m_busy[v]);
      co[v] = rq[v] && !m_stopq[v] && (hd[v] ? !m_obusy[v] : m_obusy[v]);
    end
    gc = lowest(cc); go = lowest(co);
    e.gc = gc; e.go = go; e.tag = tag;
    sb.push_back(e);
    for (int v = 0; v < NV; v++) begin
      m_cnt[v] = m_cnt[v] - int'(gc[v]) + int'(cv && cvc == v);
      m_busy[v] = (m_busy[v] | (gc[v] & hd[v])) & ~(gc[v] & tl[v]);
      m_obusy[v] = (m_obusy[v] | (go[v] & hd[v])) & ~(go[v] & tl[v]);
      m_stopq[v] = st[v];
    end
  endtask

  // monitor: pops expected grants and compares mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, "/R9"}, "credit grant", int'(gnt_c), int'(e.gc));
        chk({e.tag, "/R10"}, "stop grant", int'(gnt_o), int'(e.go));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int v = 0; v < NV; v++) begin
      m_cnt[v] = DEPTH; m_busy[v] = 0; m_obusy[v] = 0; m_stopq[v] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state; R6 / R9 two heads, VC1 beats VC2
    step("R1", 4'b0110, 4'b0110, 4'b0000, 0, 0, 4'b0000);
    // R9 body VC1 vs head VC0: VC0 wins
    step("R9", 4'b0011, 4'b0001, 4'b0000, 0, 0, 4'b0000);
    // R7 body VC1 alone
    step("R7", 4'b0010, 4'b0000, 4'b0000, 0, 0, 4'b0100);
    // R7 body on unowned VC3 refused; R10 VC2 stopped
    step("R7", 4'b1100, 4'b0100, 4'b0000, 0, 0, 4'b0000);
    // R6 head on owned VC1 refused
    step("R6", 4'b0010, 4'b0010, 4'b0000, 0, 0, 4'b0000);
    step("R2", 4'b0010, 4'b0000, 4'b0000, 0, 0, 4'b0000);
    step("R2", 4'b0010, 4'b0000, 4'b0000, 0, 0, 4'b0000);
    // R5 counter of VC1 now zero: refused
    step("R5", 4'b0010, 4'b0000, 4'b0000, 0, 0, 4'b0000);
    // R3 credit return to VC1
    step("R3", 4'b0000, 4'b0000, 4'b0000, 1, 1, 4'b0000);
    // R4 + R8 tail send on VC1 with credit for VC1 in the same cycle
    step("R4", 4'b0010, 4'b0000, 4'b0010, 1, 1, 4'b0000);
    // R8 single-flit packet on VC3
    step("R8", 4'b1000, 4'b1000, 4'b1000, 0, 0, 4'b0000);
    // R10 credits ignored in stop mode, refill credit mode
    step("R10", 4'b0000, 4'b0000, 4'b0000, 1, 1, 4'b1111);
    step("R10", 4'b1111, 4'b1111, 4'b0000, 1, 1, 4'b0000);
    step("R3", 4'b0000, 4'b0000, 4'b0000, 0, 0, 4'b0000);
    // mixed phase with legal credit returns
    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      int cvc;
      bit cv;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cvc = int'(lf[9:8]);
      cv = lf[10] && (m_cnt[cvc] < DEPTH);
      step("R4", lf[3:0], lf[7:4], lf[11:8] ^ lf[15:12], cv, cvc, lf[15:12] & lf[3:0]);
    end
    step("R2", 4'b0000, 4'b0000, 4'b0000, 0, 0, 4'b0000);
    @(negedge clk);
    state_check("R3");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule